// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Controller

This block is a memory-mapped serial peripheral port. It moves one byte per frame, most significant bit first, and it can work as the clock master or as a slave. Three registers are reached through a simple synchronous bus that has a write strobe, an address and registered read data. The control register sets enable, role, clock polarity, clock phase, a two-bit rate code and an interrupt enable. The status register holds a sticky completion flag and a sticky collision flag. The data register starts transfers when written and returns the received byte when read.

In master mode the block divides the system clock to make the serial clock. It drives MOSI, samples MISO and holds its select output low for the whole frame. In slave mode it resynchronises the external serial clock, the select line and MOSI to the system clock, and it drives MISO only while its select input is low. The bus writes the byte to be sent into the data register before the frame begins. A completed frame raises an interrupt request, which is gated by the local enable and by a global enable input.

Top module: `spi_ctl`

## Requirements
- R1: After reset, the control register and the status register read as 0x00. `ss_n_o` is 1, and `sclk_o`, `irq` and `miso_oe` are 0.
- R2: The register map is: address 0 for control, address 1 for status and address 2 for data. In master mode (control bit 0 = enable set to 1, bit 1 = master set to 1), a write to address 2 while no frame is running starts a frame. `ss_n_o` is then low for exactly 16 serial half-periods, and `sclk_o` makes 8 full cycles.
- R3: Control bit 2 sets the idle level of `sclk_o`: 0 gives low and 1 gives high. While no frame runs, `sclk_o` follows this bit one cycle later.
- R4: The rate code is control bits 5:4. With `slow_mode`=0, codes 0, 1, 2 and 3 divide the system clock by 2, 8, 32 and 64. With `slow_mode`=1 they divide by 4, 16, 64 and 128.
- R5: Control bit 3 is the phase bit. With phase 0, the first bit is on the data output before the first edge, data is sampled on the leading edge and data changes on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge. In both cases bits go out and come in MSB first.
- R6: Status bit 7 is set when the 8th bit of a frame completes. Writing a status word with bit 7 set clears it. Status bits 5:0 always read as 0.
- R7: `irq` is 1 exactly one cycle after the completion flag, control bit 6 (interrupt enable) and `glb_irq_en` are all 1.
- R8: A write to address 2 while a frame runs sets status bit 6. This flag stays set until a status write with bit 6 set clears it. The write does not change the bits sent or received in the frame.
- R9: In slave mode (enable 1, master 0), a frame runs while `ss_n_i` is low. With phase 0, the MSB of the last byte written is on `miso_o` soon after `ss_n_i` falls. The rate code has no effect.
- R10: In slave mode with `ss_n_i` high, `miso_oe` is 0, clock edges are ignored and neither the status register nor the data register changes.
- R11: A read of address 2 returns the last byte fully received, in either role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid one cycle after addr |
| slow_mode | input | 1 | Selects the doubled divide ratios |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| ss_n_o | output | 1 | Active-low frame select driven in master mode |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sclk_i | input | 1 | Serial clock input in slave mode |
| ss_n_i | input | 1 | Active-low slave select input |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Output enable for miso_o |

## Verification
On every cycle, the assertions check the following: the interrupt gating and its one-cycle lag, the stickiness of both status flags until a matching clear, the idle level of the master clock, that the master clock toggles only inside a frame, and that MISO is driven only in the slave role. Only the bench scenarios can show the bit order, the phase-dependent sample and launch points, the exact frame length for each rate code in both clock modes, that a colliding write leaves the running frame untouched, and that a slave ignores activity while it is deselected.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_DATA = 2;

  typedef struct packed {
    logic       ie;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // serial half-period in system clocks
  function automatic int half_cycles(input logic [1:0] rate, input logic slow);
    int b;
    case (rate)
      2'd0:    b = 1;
      2'd1:    b = 4;
      2'd2:    b = 16;
      default: b = 32;
    endcase
    return slow ? (b * 2) : b;
  endfunction

endpackage

// File: rtl/spi_ctl_mclk.sv
module spi_ctl_mclk #(
  parameter int BITS = 8,
  parameter int HCW  = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           cpol,
  input  logic [HCW-1:0] hlim,
  output logic           busy,
  output logic           sclk,
  output logic           lead,
  output logic           trail
);
  localparam int EW = $clog2(2 * BITS);

  logic [HCW-1:0] hcnt, hlim_q;
  logic [EW-1:0]  ecnt;
  logic           tick;

  assign tick  = busy && (hcnt == hlim_q);
  assign lead  = tick && !ecnt[0];
  assign trail = tick && ecnt[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      hlim_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sclk   <= cpol;
      hcnt   <= '0;
      ecnt   <= '0;
      hlim_q <= hlim;
    end else if (busy) begin
      if (tick) begin
        hcnt <= '0;
        sclk <= ~sclk;
        ecnt <= ecnt + 1'b1;
        if (ecnt == EW'(2 * BITS - 1)) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else begin
      sclk <= cpol;
    end
  end
endmodule

// File: rtl/spi_ctl_sfront.sv
module spi_ctl_sfront (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cpol,
  input  logic sclk_i,
  input  logic ss_n_i,
  input  logic mosi_i,
  output logic ss_act,
  output logic ss_fall,
  output logic lead,
  output logic trail,
  output logic mosi_s
);
  logic sck_m, sck_s, sck_p;
  logic ss_m, ss_s, ss_p;
  logic mo_m;
  logic edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m <= 1'b0; sck_s <= 1'b0; sck_p <= 1'b0;
      ss_m  <= 1'b1; ss_s  <= 1'b1; ss_p  <= 1'b1;
      mo_m  <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sck_m <= sclk_i; sck_s <= sck_m; sck_p <= sck_s;
      ss_m  <= ss_n_i; ss_s  <= ss_m;  ss_p  <= ss_s;
      mo_m  <= mosi_i; mosi_s <= mo_m;
    end
  end

  assign ss_act    = en && !ss_s;
  assign ss_fall   = ss_act && ss_p;
  assign edge_seen = ss_act && !ss_fall && (sck_s != sck_p);
  assign lead      = edge_seen && (sck_p == cpol);
  assign trail     = edge_seen && (sck_p != cpol);
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] ld_data,
  input  logic            lead,
  input  logic            trail,
  input  logic            cpha,
  input  logic            din,
  output logic            dout,
  output logic [BITS-1:0] rx_byte,
  output logic            done
);
  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] shreg, nxt;
  logic [CW-1:0]   cnt;
  logic            samp;

  assign nxt = {shreg[BITS-2:0], (cpha ? din : samp)};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      rx_byte <= '0;
      cnt     <= '0;
      samp    <= 1'b0;
      dout    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        shreg <= ld_data;
        dout  <= ld_data[BITS-1];
        cnt   <= '0;
      end else begin
        if (lead) begin
          if (!cpha) samp <= din;
          else       dout <= shreg[BITS-1];
        end
        if (trail) begin
          shreg <= nxt;
          if (!cpha) dout <= shreg[BITS-2];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(BITS - 1)) begin
            done    <= 1'b1;
            rx_byte <= nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 2,
  parameter int HCW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          slow_mode,
  input  logic          glb_irq_en,
  output logic          irq,
  output logic          sclk_o,
  output logic          ss_n_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sclk_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe
);
  ctrl_t         ctrl;
  logic          done_f, coll_f;
  logic [DW-1:0] tx_buf, rx_reg;

  logic is_m, is_s, busy, dwr, start;
  logic m_busy, m_lead, m_trail;
  logic s_act, s_fall, s_lead, s_trail, s_mosi;
  logic e_dout, e_done;
  logic [DW-1:0]  e_rx;
  logic [HCW-1:0] hlim;

  assign is_m  = ctrl.en && ctrl.master;
  assign is_s  = ctrl.en && !ctrl.master;
  assign busy  = (is_m && m_busy) || s_act;
  assign dwr   = wr_en && (addr == AW'(ADR_DATA));
  assign start = dwr && is_m && !busy;
  assign hlim  = HCW'(half_cycles(ctrl.rate, slow_mode) - 1);

  spi_ctl_mclk #(.BITS(DW), .HCW(HCW)) u_mclk (
    .clk(clk), .rst(rst), .start(start), .cpol(ctrl.cpol), .hlim(hlim),
    .busy(m_busy), .sclk(sclk_o), .lead(m_lead), .trail(m_trail)
  );

  spi_ctl_sfront u_sfront (
    .clk(clk), .rst(rst), .en(is_s), .cpol(ctrl.cpol),
    .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .ss_act(s_act), .ss_fall(s_fall), .lead(s_lead), .trail(s_trail),
    .mosi_s(s_mosi)
  );

  spi_ctl_shift #(.BITS(DW)) u_shift (
    .clk(clk), .rst(rst),
    .load(start || s_fall),
    .ld_data(is_m ? wdata : tx_buf),
    .lead(is_m ? m_lead : s_lead),
    .trail(is_m ? m_trail : s_trail),
    .cpha(ctrl.cpha),
    .din(is_m ? miso_i : s_mosi),
    .dout(e_dout), .rx_byte(e_rx), .done(e_done)
  );

  assign ss_n_o  = ~m_busy;
  assign mosi_o  = is_m && e_dout;
  assign miso_o  = s_act && e_dout;
  assign miso_oe = s_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      done_f <= 1'b0;
      coll_f <= 1'b0;
      tx_buf <= '0;
      rx_reg <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && (addr == AW'(ADR_CTRL))) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_en && (addr == AW'(ADR_STAT))) begin
        if (wdata[DW-1]) done_f <= 1'b0;
        if (wdata[DW-2]) coll_f <= 1'b0;
      end
      if (dwr) begin
        if (busy) coll_f <= 1'b1;
        else      tx_buf <= wdata;
      end
      if (e_done) begin
        done_f <= 1'b1;
        rx_reg <= e_rx;
      end
      irq <= done_f && ctrl.ie && glb_irq_en;
      case (addr)
        AW'(ADR_CTRL): rdata <= {{(DW-CTRL_W){1'b0}}, ctrl};
        AW'(ADR_STAT): rdata <= {done_f, coll_f, {(DW-2){1'b0}}};
        AW'(ADR_DATA): rdata <= rx_reg;
        default:       rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input logic          glb_irq_en,
  input logic          done_f,
  input logic          coll_f,
  input logic          sclk_o,
  input logic          ss_n_o,
  input logic [CW-1:0] ctrl_bits,
  input logic          miso_oe
);
  logic st_wr;
  assign st_wr = wr_en && (addr == AW'(1));

  // R7: request only follows a set flag with both enables
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(done_f) && $past(glb_irq_en) && $past(ctrl_bits[6])));

  // R6: completion flag clears only through a status write
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(done_f) && !($past(st_wr) && $past(wdata[DW-1]))) |-> done_f);

  // R8: collision flag clears only through a status write
  a_r8_coll_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(coll_f) && !($past(st_wr) && $past(wdata[DW-2]))) |-> coll_f);

  // R3: idle clock level follows polarity
  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    (ss_n_o && $past(ss_n_o)) |-> (sclk_o == $past(ctrl_bits[2])));

  // R2: clock toggles only inside a selected frame
  a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    ((sclk_o != $past(sclk_o)) && ($past(ctrl_bits[2]) == $past(ctrl_bits[2], 2))
      && $past(ss_n_o, 2)) |-> !$past(ss_n_o));

  // R10: MISO driven only in enabled slave role
  a_r10_miso_role: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (ctrl_bits[0] && !ctrl_bits[1]));
endmodule

bind spi_ctl spi_ctl_chk #(.DW(DW), .AW(AW), .CW(spi_ctl_pkg::CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .glb_irq_en(glb_irq_en), .done_f(done_f), .coll_f(coll_f),
  .sclk_o(sclk_o), .ss_n_o(ss_n_o), .ctrl_bits(ctrl), .miso_oe(miso_oe)
);

// File: tb/spi_ctl_tb_top.sv
module spi_ctl_tb_top;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       slow_mode = 1'b0, glb_irq_en = 1'b0, irq;
  logic       sclk_o, ss_n_o, mosi_o, miso_i = 1'b0;
  logic       sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_o, miso_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_ctl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .slow_mode(slow_mode), .glb_irq_en(glb_irq_en), .irq(irq),
    .sclk_o(sclk_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] rate, input logic slow);
    int b;
    case (rate)
      2'd0: b = 2; 2'd1: b = 8; 2'd2: b = 32; default: b = 64;
    endcase
    return slow ? 2 * b : b;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic m_xfer(input logic cpol, input logic cpha, input logic [1:0] rate,
                        input logic slow, input logic ie, input logic gie,
                        input logic [7:0] tb, input logic [7:0] sb, input logic coll);
    logic [7:0] got, v;
    logic prev;
    int k, low;
    slow_mode = slow; glb_irq_en = gie;
    wr(2'd0, {1'b0, ie, rate, cpha, cpol, 1'b1, 1'b1});
    wr(2'd1, 8'hC0);
    miso_i = sb[7]; k = 0; got = 8'd0; prev = cpol; low = 0;
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = tb;
    @(negedge clk); wr_en = 1'b0;
    forever begin
      if (sclk_o != prev) begin
        if (prev == cpol) begin
          if (!cpha) got = {got[6:0], mosi_o};
          else begin miso_i = sb[7-k]; k++; end
        end else begin
          if (cpha) got = {got[6:0], mosi_o};
          else begin k++; if (k < 8) miso_i = sb[7-k]; end
        end
        prev = sclk_o;
      end
      if (ss_n_o || low > 5000) break;
      low++;
      if (coll && low == 5) begin wr_en = 1'b1; addr = 2'd2; wdata = ~tb; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R5 master MOSI byte", got, tb);
    chk("R2/R4 frame length", low, 8 * div_of(rate, slow));
    repeat (3) @(negedge clk);
    chk("R3 idle level", sclk_o, cpol);
    chk("R7 irq gating", irq, ie & gie);
    rd(2'd2, v); chk("R11 received byte", v, sb);
    rd(2'd1, v); chk("R6/R8 status", v, {1'b1, coll, 6'd0});
  endtask

  task automatic s_xfer(input logic cpol, input logic cpha, input logic [7:0] tx,
                        input logic [7:0] mb);
    logic [7:0] got, v;
    wr(2'd0, {1'b0, 1'b0, 2'($urandom_range(0, 3)), cpha, cpol, 1'b0, 1'b1});
    wr(2'd1, 8'hC0);
    sclk_i = cpol;
    wr(2'd2, tx);
    rd(2'd1, v); chk("R8 idle slave write no collision", v, 8'h00);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 miso enabled", miso_oe, 1'b1);
    if (!cpha) chk("R9 first bit before edge", miso_o, tx[7]);
    got = 8'd0;
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = mb[7-i];
        repeat (H) @(negedge clk);
        got = {got[6:0], miso_o};
        sclk_i = ~cpol;
        repeat (H) @(negedge clk);
        sclk_i = cpol;
      end else begin
        sclk_i = ~cpol; mosi_i = mb[7-i];
        repeat (H) @(negedge clk);
        got = {got[6:0], miso_o};
        sclk_i = cpol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    chk("R9 slave MISO byte", got, tx);
    rd(2'd1, v); chk("R6 slave completion", v, 8'h80);
    rd(2'd2, v); chk("R11 slave received byte", v, mb);
    wr(2'd2, 8'h5A);
    rd(2'd1, v); chk("R8 slave collision", v, 8'hC0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 miso released", miso_oe, 1'b0);
    wr(2'd1, 8'hC0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ss_n_o", ss_n_o, 1'b1);
    chk("R1 sclk_o", sclk_o, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 miso_oe", miso_oe, 1'b0);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd0, v); chk("R1 control", v, 8'h00);

    // directed corners: fastest, slowest with collision
    m_xfer(1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0);
    m_xfer(1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b1);
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R8 clear collision only", v, 8'h80);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk("R6 clear completion", v, 8'h00);
    rd(2'd2, v); chk("R8 collision kept received byte", v, 8'h7E);

    for (int n = 0; n < 10; n++)
      m_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));

    s_xfer(1'b0, 1'b0, 8'hC3, 8'h96);
    s_xfer(1'b1, 1'b1, 8'h1E, 8'hE1);
    for (int n = 0; n < 3; n++)
      s_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom));

    // R10: deselected slave ignores clock edges
    wr(2'd0, 8'h01);
    for (int i = 0; i < 16; i++) begin
      mosi_i = i[1]; sclk_i = ~sclk_i;
      repeat (H) @(negedge clk);
      if (miso_oe) chk("R10 miso stays off", miso_oe, 1'b0);
    end
    rd(2'd1, v); chk("R10 status unchanged", v, 8'h00);
    rd(2'd2, v); total++;
    if (v === 8'h00) begin bad++; $display("FAIL R10 data changed actual=%0h expected=prior", v); end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule